// File: doc/BRIEF.md
# Multi-Level Cell Transmit Scheduler

This block chooses which virtual-connection identifier receives the next outgoing cell slot. Constant-rate connections that have been found conforming come in on a direct slot-request port and never wait in a queue. Every other conforming connection (unspecified, variable or available rate) is written, together with a priority level, into one of a bank of per-level identifier queues. Level 0 is the most urgent and the highest-numbered level is the least urgent.

A transmit opportunity exists in every cycle where the downstream cell FIFO reports room (`tx_ready` high). In that cycle the registered output takes the pending constant-rate request if there is one. Otherwise it takes the head of the lowest-numbered non-empty queue. If nothing is pending, the output goes idle. The choice is made again at every opportunity, so an urgent level is served for as long as it has cells, and the slots it leaves unused go to less urgent levels. An empty urgent level never holds back a busy one.

Top module: `cell_slot_scheduler`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tx_valid` is low and `enq_ready` is high for every level.
- R2: A constant-rate request is accepted (`cbr_ready` high) only in a cycle with `tx_ready` high. The identifier appears on `tx_id` with `tx_cbr` = 1 after the next clock edge. A request presented while `tx_ready` is low produces no output.
- R3: When a constant-rate request and queued entries are both pending at the same opportunity, the constant-rate request is the one sent, and no queue is popped in that cycle.
- R4: A write with `enq_valid` high goes into the queue selected by `enq_level`. When that queue holds `Q_DEPTH` entries, `enq_ready` is low and the write is dropped: the dropped identifier is never transmitted.
- R5: When no constant-rate request is present, the opportunity goes to the head of the non-empty queue with the smallest level number.
- R6: Priority is evaluated again at every opportunity. An entry written into a more urgent level while a less urgent level is draining is sent at the first opportunity after it becomes visible. Empty urgent levels never block less urgent ones.
- R7: With `tx_ready` low, `tx_valid`, `tx_id` and `tx_cbr` hold their values and no queue is popped.
- R8: At an opportunity with no constant-rate request and all queues empty, `tx_valid` becomes low and no queue changes.
- R9: Each level sends its identifiers in the order they were written. This holds when a write and a pop hit the same level in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cbr_valid | input | 1 | Constant-rate slot request pending |
| cbr_id | input | ID_W | Identifier of the constant-rate connection |
| cbr_ready | output | 1 | Constant-rate request taken this cycle |
| enq_valid | input | 1 | Write of a conforming queued-class identifier |
| enq_level | input | LVL_W | Target priority level, 0 most urgent |
| enq_id | input | ID_W | Identifier to write |
| enq_ready | output | 1 | Target level has room |
| tx_ready | input | 1 | Downstream cell FIFO not full (opportunity) |
| tx_valid | output | 1 | Selected identifier valid |
| tx_id | output | ID_W | Selected connection identifier |
| tx_cbr | output | 1 | Selected identifier came from the constant-rate path |

## Verification
The bench builds the block with its defaults: 8-bit identifiers, sixteen levels and four-entry queues. With four-entry queues, a full level and a dropped write are reached in a handful of cycles. Sixteen levels let the bench use level 0 and level 15 in one pattern. At this size, writes can also land in a level during a cycle where that same level is popped, and an urgent entry can arrive while a less urgent level is draining.

// File: rtl/cell_sched_pkg.sv
package cell_sched_pkg;
  // Source of the cell loaded into the output register at an opportunity.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CBR   = 2'd1,
    SRC_QUEUE = 2'd2
  } slot_src_e;

  // Width helper that never returns zero.
  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cell_id_queue.sv
module cell_id_queue #(
  parameter int ID_W  = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic            pop,
  output logic [ID_W-1:0] head_id,
  output logic            empty,
  output logic            full
);
  localparam int PW = cell_sched_pkg::safe_clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  // Small storage array: no reset, so it maps onto distributed RAM.
  logic [ID_W-1:0] mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_id = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));

  // R4: the arbiter side never writes into a full queue
  a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R9: a pop is only issued against a queue that holds an entry
  a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R9: a simultaneous write and pop leaves the occupancy unchanged
  a_r9_push_pop_balance: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(count));
endmodule

// File: rtl/level_priority_pick.sv
module level_priority_pick #(
  parameter int  N  = 16,
  localparam int IW = cell_sched_pkg::safe_clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Fixed priority: the lowest index wins, so scan from the top down.
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_slot_scheduler.sv
module cell_slot_scheduler #(
  parameter int  ID_W    = 8,
  parameter int  NUM_LVL = 16,
  parameter int  Q_DEPTH = 4,
  localparam int LVL_W   = cell_sched_pkg::safe_clog2(NUM_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cbr_valid,
  input  logic [ID_W-1:0]  cbr_id,
  output logic             cbr_ready,
  input  logic             enq_valid,
  input  logic [LVL_W-1:0] enq_level,
  input  logic [ID_W-1:0]  enq_id,
  output logic             enq_ready,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [ID_W-1:0]  tx_id,
  output logic             tx_cbr
);
  import cell_sched_pkg::*;

  logic [NUM_LVL-1:0] q_full, q_empty, q_push, q_pop;
  logic [ID_W-1:0]    q_head [NUM_LVL];
  logic [NUM_LVL-1:0] pick_grant;
  logic [LVL_W-1:0]   pick_idx;
  logic               pick_any;
  logic               lvl_full;
  slot_src_e          src;

  // Full flag of the addressed level; out-of-range levels read as full.
  always_comb begin
    lvl_full = 1'b1;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (enq_level == LVL_W'(i)) lvl_full = q_full[i];
    end
  end
  assign enq_ready = !lvl_full;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign q_push[g] = enq_valid && (enq_level == LVL_W'(g)) && !q_full[g];
    cell_id_queue #(.ID_W(ID_W), .DEPTH(Q_DEPTH)) u_q (
      .clk     (clk),
      .rst     (rst),
      .push    (q_push[g]),
      .push_id (enq_id),
      .pop     (q_pop[g]),
      .head_id (q_head[g]),
      .empty   (q_empty[g]),
      .full    (q_full[g])
    );
  end

  level_priority_pick #(.N(NUM_LVL)) u_pick (
    .req   (~q_empty),
    .grant (pick_grant),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  // Opportunity arbitration: constant-rate first, then the queue bank.
  always_comb begin
    if (!tx_ready)      src = SRC_NONE;
    else if (cbr_valid) src = SRC_CBR;
    else if (pick_any)  src = SRC_QUEUE;
    else                src = SRC_NONE;
  end

  assign q_pop     = (src == SRC_QUEUE) ? pick_grant : '0;
  assign cbr_ready = tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_cbr   <= 1'b0;
      tx_id    <= '0;
    end else if (tx_ready) begin
      tx_valid <= (src != SRC_NONE);
      tx_cbr   <= (src == SRC_CBR);
      tx_id    <= (src == SRC_CBR) ? cbr_id : q_head[pick_idx];
    end
  end

  // R1: the output is idle straight after reset
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !tx_valid);
  // R3: a constant-rate request wins its opportunity
  a_r3_cbr_first: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && cbr_valid) |=> (tx_valid && tx_cbr && tx_id == $past(cbr_id)));
  // R3: no queue loses an entry when the constant-rate path wins
  a_r3_no_pop_on_cbr: assert property (@(posedge clk) disable iff (rst)
    cbr_valid |-> (q_pop == '0));
  // R5: the popped level has no non-empty more urgent level
  a_r5_most_urgent: assert property (@(posedge clk) disable iff (rst)
    (q_pop != '0) |-> (((q_pop - 1'b1) & ~q_empty) == '0));
  // R5: at most one level is popped per opportunity
  a_r5_single_pop: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_pop));
  // R7: without room downstream the output register holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !tx_ready |=> ($stable(tx_valid) && $stable(tx_id) && $stable(tx_cbr)));
  // R7: without room downstream nothing is popped
  a_r7_no_pop: assert property (@(posedge clk) disable iff (rst)
    !tx_ready |-> (q_pop == '0));
  // R8: nothing pending gives an idle slot
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && !cbr_valid && (&q_empty)) |=> !tx_valid);
endmodule

// File: tb/cell_slot_scheduler_test.sv
module cell_slot_scheduler_test;
  localparam int ID_W = 8, NUM_LVL = 16, Q_DEPTH = 4, LVL_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cbr_valid = 1'b0, enq_valid = 1'b0, tx_ready = 1'b0;
  logic [ID_W-1:0]  cbr_id = '0, enq_id = '0;
  logic [LVL_W-1:0] enq_level = '0;
  logic cbr_ready, enq_ready, tx_valid, tx_cbr;
  logic [ID_W-1:0] tx_id;

  always #5 clk = ~clk;

  cell_slot_scheduler #(.ID_W(ID_W), .NUM_LVL(NUM_LVL), .Q_DEPTH(Q_DEPTH)) uut (
    .clk(clk), .rst(rst),
    .cbr_valid(cbr_valid), .cbr_id(cbr_id), .cbr_ready(cbr_ready),
    .enq_valid(enq_valid), .enq_level(enq_level), .enq_id(enq_id), .enq_ready(enq_ready),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_id(tx_id), .tx_cbr(tx_cbr));

  int checks = 0, errors = 0, xfers = 0;
  bit done = 1'b0;
  logic [ID_W:0] sb_q [$];
  string         tag_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input int lvl, input int id);
    enq_valid = 1'b1; enq_level = LVL_W'(lvl); enq_id = ID_W'(id);
    step();
    enq_valid = 1'b0;
  endtask

  task automatic expect_cell(input bit c, input int id, input string tag);
    sb_q.push_back({c, ID_W'(id)});
    tag_q.push_back(tag);
  endtask

  task automatic drain(input int n);
    tx_ready = 1'b1;
    repeat (n) step();
    tx_ready = 1'b0;
  endtask

  // Monitor: a cell transfers at the next edge when valid and ready are both high.
  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready) begin
      xfers++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R5", "unexpected cell", {tx_cbr, tx_id}, 0);
      end else begin
        logic [ID_W:0] exp;
        string tg;
        exp = sb_q.pop_front();
        tg  = tag_q.pop_front();
        check({tx_cbr, tx_id} == exp, tg, "cell {cbr,id}", {tx_cbr, tx_id}, exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    @(negedge clk);
    check(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
    check(enq_ready == 1'b1, "R1", "enq_ready in reset", enq_ready, 1);
    rst = 1'b0;
    step();
    @(negedge clk);
    check(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);

    // R5: mixed levels, most urgent first; R7: nothing chosen without room
    push(5, 'h51); push(5, 'h52); push(2, 'h21); push(15, 'hF1);
    @(negedge clk);
    check(tx_valid == 1'b0, "R7", "tx_valid without room", tx_valid, 0);
    expect_cell(0, 'h21, "R5"); expect_cell(0, 'h51, "R5");
    expect_cell(0, 'h52, "R5"); expect_cell(0, 'hF1, "R5");
    drain(7);
    @(negedge clk);
    check(tx_valid == 1'b0, "R8", "tx_valid when idle", tx_valid, 0);
    check(xfers == 4, "R8", "transfers after idle", xfers, 4);

    // R2: request waits for room; R3: it then beats a queued entry
    push(0, 'h01);
    cbr_valid = 1'b1; cbr_id = 'hC1;
    repeat (2) step();
    @(negedge clk);
    check(cbr_ready == 1'b0, "R2", "cbr_ready without room", cbr_ready, 0);
    check(tx_valid == 1'b0, "R2", "tx_valid without room", tx_valid, 0);
    expect_cell(1, 'hC1, "R3"); expect_cell(0, 'h01, "R3");
    tx_ready = 1'b1;
    step();
    cbr_valid = 1'b0;
    drain(4);

    // R4: full level refuses; R7: output holds without room
    push(3, 'h30); push(3, 'h31); push(3, 'h32); push(3, 'h33);
    enq_level = 3;
    @(negedge clk);
    check(enq_ready == 1'b0, "R4", "enq_ready full level", enq_ready, 0);
    enq_level = 4;
    @(negedge clk);
    check(enq_ready == 1'b1, "R4", "enq_ready other level", enq_ready, 1);
    push(3, 'h3F);
    expect_cell(0, 'h30, "R4"); expect_cell(0, 'h31, "R4");
    expect_cell(0, 'h32, "R4"); expect_cell(0, 'h33, "R4");
    tx_ready = 1'b1;
    step();
    tx_ready = 1'b0;
    repeat (3) step();
    @(negedge clk);
    check(tx_valid == 1'b1 && tx_id == 'h30, "R7", "held cell", {tx_valid, tx_id}, 'h130);
    enq_level = 3;
    @(negedge clk);
    check(enq_ready == 1'b1, "R4", "room after head taken", enq_ready, 1);
    drain(6);

    // R9: write and pop on the same level in the same cycle
    push(7, 'h71);
    expect_cell(0, 'h71, "R9"); expect_cell(0, 'h72, "R9");
    expect_cell(0, 'h73, "R9"); expect_cell(0, 'h74, "R9");
    tx_ready = 1'b1;
    enq_valid = 1'b1; enq_level = 7;
    enq_id = 'h72; step();
    enq_id = 'h73; step();
    enq_id = 'h74; step();
    enq_valid = 1'b0;
    repeat (4) step();
    tx_ready = 1'b0;

    // R6: urgent entry arriving mid-drain is served at once
    push(9, 'h9A); push(9, 'h9B); push(9, 'h9C);
    expect_cell(0, 'h9A, "R6"); expect_cell(0, 'h9B, "R6");
    expect_cell(0, 'h11, "R6"); expect_cell(0, 'h9C, "R6");
    tx_ready = 1'b1;
    step();
    enq_valid = 1'b1; enq_level = 1; enq_id = 'h11;
    step();
    enq_valid = 1'b0;
    repeat (5) step();
    tx_ready = 1'b0;
    step();

    @(negedge clk);
    check(sb_q.size() == 0, "R4", "cells not sent", sb_q.size(), 0);
    check(xfers == 18, "R4", "total transfers", xfers, 18);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule